// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 65,536 sixteen-bit words. The host hands over one access at a time as a word address, write data, a two-bit byte mask and a read/write flag. The block then drives the memory's active-low select, output-enable, write-enable and per-byte strobes, and it controls the direction of the shared 16-bit data bus. The bus is brought out as separate output data, input data and an output-enable, which the pad ring turns into a tri-state buffer.

Each cycle's length comes from the memory's minimum timing, which is given in picoseconds together with the clock period. These are turned into whole clocks, rounded up, with a minimum of one clock each. A write is ended by raising the byte strobes while chip select and write enable stay low. The data stays driven for at least one clock after that terminating edge.

The request side follows valid/ready rules. The host keeps `req_valid` and its fields stable until a rising edge at which `req_ready` is high. `req_ready` is high only while the sequencer is idle. The response side has no back-pressure: `rsp_valid` is a one-clock pulse, and for reads `rsp_rdata` is valid while that pulse is high.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is held and just after it, all five memory strobes are high, `mem_dq_oe` is low, `rsp_valid` is low and `req_ready` is high.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is then low from the next cycle until the cycle in which `rsp_valid` pulses.
- R3: A read holds chip select and output enable low for ACC clocks. Mask bit 0 drives the lower-byte strobe, which covers bits 7:0, and mask bit 1 drives the upper-byte strobe, which covers bits 15:8. `rsp_rdata` returns the stored byte for each selected lane and zero for each unselected lane.
- R4: A write changes only the bytes whose mask bit is set: mask bit 0 covers bits 7:0 and mask bit 1 covers bits 15:8. The other byte of the stored word keeps its value.
- R5: While write enable is low, chip select is low and output enable is high. The selected byte strobes are low together with write enable for WP clocks, and `mem_dq_oe` is high throughout.
- R6: A write is ended by the byte strobes rising while write enable is still low. The data bus stays driven with unchanged data for HOLD clocks after that edge.
- R7: Output enable has been high for at least one clock when write enable falls.
- R8: When a request's direction differs from the previous access, TURN clocks with all strobes high and the bus released are inserted before the new access.
- R9: `mem_dq_oe` is never high while output enable is low.
- R10: A write with mask 00 asserts no byte strobe, leaves the memory unchanged, and is still acknowledged. A read with mask 00 returns zero.
- R11: `rsp_valid` is a single-clock pulse. It rises ACC+1 clocks after a read is taken and WP+HOLD+1 clocks after a write is taken, plus TURN when R8 applies. With the default parameters ACC=2, WP=2, HOLD=1 and TURN=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lanes: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with `rsp_valid` after a read |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_i | input | 16 | Data returned from the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |

## Verification
The hardest case to reach from the ports is a direction change that arrives in the same cycle as the previous acknowledge. This is the case where the turnaround, the output-enable rule and the data hold after the terminating edge all meet. The bench issues each new request in the acknowledge cycle itself, so every write-after-read and read-after-write pair runs at minimum spacing. A memory model in the bench commits each byte only when its strobe rises, so a too-short hold or a stray lane shows up as a wrong value on a later readback.

// File: rtl/sram_timing_pkg.sv
package sram_timing_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_RD,
    ST_WR_PULSE,
    ST_WR_HOLD
  } sram_state_e;

  // Whole clocks covering a time span, never less than one.
  function automatic int clocks_for(input int span_ps, input int period_ps);
    int c;
    c = (span_ps + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_counter.sv
module sram_cycle_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sram_lane_sel.sv
module sram_lane_sel #(
  parameter int LANES = 2
) (
  input  logic             en,
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] sel_n
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sel_n[g] = ~(en & mask[g]);
  end
endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_wdata,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              drive_next,
  input  logic              capture,
  input  logic [LANES-1:0]  lane_mask,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_masked;

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign rd_masked[g*8 +: 8] = lane_mask[g] ? dq_in[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wdata_q <= '0;
      dq_oe   <= 1'b0;
      rdata   <= '0;
    end else begin
      if (load_wdata) wdata_q <= wdata_in;
      dq_oe <= drive_next;
      if (capture) rdata <= rd_masked;
    end
  end

  assign dq_out = wdata_q;
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_timing_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int CLK_PS     = 5000,
  parameter int T_AA_PS    = 10000,
  parameter int T_RC_PS    = 10000,
  parameter int T_OEA_PS   = 5000,
  parameter int T_WP_PS    = 8000,
  parameter int T_BW_PS    = 8000,
  parameter int T_DS_PS    = 6000,
  parameter int T_WC_PS    = 10000,
  parameter int T_TURN_PS  = 4000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic [DATA_W/8-1:0]     req_mask,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_ce_n,
  output logic                    mem_oe_n,
  output logic                    mem_we_n,
  output logic                    mem_ub_n,
  output logic                    mem_lb_n,
  output logic [DATA_W-1:0]       mem_dq_o,
  input  logic [DATA_W-1:0]       mem_dq_i,
  output logic                    mem_dq_oe
);
  localparam int LANES    = DATA_W / 8;
  localparam int ACC_CLK  = clocks_for(max_of(max_of(T_AA_PS, T_RC_PS), T_OEA_PS), CLK_PS);
  localparam int WP_CLK   = clocks_for(max_of(max_of(T_WP_PS, T_BW_PS), T_DS_PS), CLK_PS);
  localparam int WC_CLK   = clocks_for(T_WC_PS, CLK_PS);
  localparam int HOLD_CLK = (WC_CLK > WP_CLK) ? (WC_CLK - WP_CLK) : 1;
  localparam int TURN_CLK = clocks_for(T_TURN_PS, CLK_PS);
  localparam int MAX_CLK  = max_of(max_of(ACC_CLK, WP_CLK), max_of(HOLD_CLK, TURN_CLK));
  localparam int CNT_W    = ($clog2(MAX_CLK) < 1) ? 1 : $clog2(MAX_CLK);

  sram_state_e         state, state_n;
  logic                op_wr;
  logic [LANES-1:0]    op_mask;
  logic                have_prev, prev_wr;
  logic                accept, capture, ack_n;
  logic                cnt_load, cnt_done;
  logic [CNT_W-1:0]    cnt_val;
  logic [LANES-1:0]    lane_mask_n, sel_n_next, sel_n_q;
  logic                lane_en_n, drive_n;

  sram_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .done(cnt_done)
  );

  // Next state and counter loads
  always_comb begin
    state_n  = state;
    cnt_load = 1'b0;
    cnt_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    ack_n    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          cnt_load = 1'b1;
          if (have_prev && (prev_wr != req_write)) begin
            state_n = ST_TURN;
            cnt_val = CNT_W'(TURN_CLK - 1);
          end else if (req_write) begin
            state_n = ST_WR_PULSE;
            cnt_val = CNT_W'(WP_CLK - 1);
          end else begin
            state_n = ST_RD;
            cnt_val = CNT_W'(ACC_CLK - 1);
          end
        end
      end
      ST_TURN: begin
        if (cnt_done) begin
          cnt_load = 1'b1;
          if (op_wr) begin
            state_n = ST_WR_PULSE;
            cnt_val = CNT_W'(WP_CLK - 1);
          end else begin
            state_n = ST_RD;
            cnt_val = CNT_W'(ACC_CLK - 1);
          end
        end
      end
      ST_RD: begin
        if (cnt_done) begin
          capture = 1'b1;
          ack_n   = 1'b1;
          state_n = ST_IDLE;
        end
      end
      ST_WR_PULSE: begin
        if (cnt_done) begin
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(HOLD_CLK - 1);
          state_n  = ST_WR_HOLD;
        end
      end
      ST_WR_HOLD: begin
        if (cnt_done) begin
          ack_n   = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // Strobes are decoded from the next state and registered
  assign lane_mask_n = accept ? req_mask : op_mask;
  assign lane_en_n   = (state_n == ST_RD) || (state_n == ST_WR_PULSE);
  assign drive_n     = (state_n == ST_WR_PULSE) || (state_n == ST_WR_HOLD);

  sram_lane_sel #(.LANES(LANES)) u_lanes (
    .en(lane_en_n), .mask(lane_mask_n), .sel_n(sel_n_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_wr     <= 1'b0;
      op_mask   <= '0;
      have_prev <= 1'b0;
      prev_wr   <= 1'b0;
      mem_addr  <= '0;
      rsp_valid <= 1'b0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      sel_n_q   <= '1;
    end else begin
      state     <= state_n;
      rsp_valid <= ack_n;
      if (accept) begin
        op_wr     <= req_write;
        op_mask   <= req_mask;
        have_prev <= 1'b1;
        prev_wr   <= req_write;
        mem_addr  <= req_addr;
      end
      mem_ce_n <= !((state_n == ST_RD) || drive_n);
      mem_oe_n <= !(state_n == ST_RD);
      mem_we_n <= !drive_n;
      sel_n_q  <= sel_n_next;
    end
  end

  assign mem_lb_n  = sel_n_q[0];
  assign mem_ub_n  = sel_n_q[LANES-1];
  assign req_ready = (state == ST_IDLE);

  sram_dq_path #(.DATA_W(DATA_W)) u_dq (
    .clk(clk), .rst(rst),
    .load_wdata(accept), .wdata_in(req_wdata),
    .drive_next(drive_n), .capture(capture), .lane_mask(op_mask),
    .dq_in(mem_dq_i), .dq_out(mem_dq_o), .dq_oe(mem_dq_oe), .rdata(rsp_rdata)
  );

  // Assertions
  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_write_strobes_R5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_dq_oe));

  assert_hold_lower_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_lb_n) && !mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o)));

  assert_hold_upper_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_ub_n) && !mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o)));

  assert_oe_before_we_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $past(mem_oe_n));

  assert_no_contention_R9: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  // Clock counts from the default timing (5 ns clock)
  localparam int ACC  = 2;
  localparam int WP   = 2;
  localparam int HOLD = 1;
  localparam int TURN = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_o;
  logic [15:0] mem_dq_i;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;

  int errors = 0;
  int checks = 0;
  bit have_prev = 0;
  bit prev_wr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_seq_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Memory model: bytes commit when their strobe ends the write
  logic [15:0] store [logic [15:0]];
  logic [15:0] refm  [logic [15:0]];

  function automatic logic [15:0] peek(input logic [15:0] a);
    return store.exists(a) ? store[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] ref_peek(input logic [15:0] a);
    return refm.exists(a) ? refm[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] exp_read(input logic [15:0] w, input logic [1:0] m);
    return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
  endfunction
  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] m);
    return {m[1] ? d[15:8] : old[15:8], m[0] ? d[7:0] : old[7:0]};
  endfunction

  always @* begin
    logic [15:0] w;
    w = peek(mem_addr);
    mem_dq_i = 16'hDEAD;
    if (!mem_ce_n && !mem_oe_n) begin
      mem_dq_i[7:0]  = !mem_lb_n ? w[7:0]  : 8'hC3;
      mem_dq_i[15:8] = !mem_ub_n ? w[15:8] : 8'h5A;
    end
  end

  bit          pend  [2];
  logic [15:0] paddr [2];
  logic [7:0]  pdata [2];
  logic        prev_we = 1'b1, prev_oe = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      for (int l = 0; l < 2; l++) begin
        logic sel_n, active;
        logic [15:0] t;
        sel_n  = (l == 0) ? mem_lb_n : mem_ub_n;
        active = !mem_ce_n && !mem_we_n && !sel_n;
        if (active) begin
          pend[l]  = 1'b1;
          paddr[l] = mem_addr;
          pdata[l] = mem_dq_o[l*8 +: 8];
          chk(mem_dq_oe && mem_oe_n, "R5 bus driven with oe high during write",
              {30'd0, mem_dq_oe, mem_oe_n}, 32'd3);
        end else if (pend[l]) begin
          chk(mem_dq_oe && (mem_dq_o[l*8 +: 8] == pdata[l]), "R6 data held after terminating edge",
              {23'd0, mem_dq_oe, mem_dq_o[l*8 +: 8]}, {23'd0, 1'b1, pdata[l]});
          t = peek(paddr[l]);
          t[l*8 +: 8] = pdata[l];
          store[paddr[l]] = t;
          pend[l] = 1'b0;
        end
      end
      if (mem_dq_oe && !mem_oe_n)
        chk(1'b0, "R9 bus contention", 32'd1, 32'd0);
      if (prev_we && !mem_we_n)
        chk(prev_oe, "R7 oe high before we falls", {31'd0, prev_oe}, 32'd1);
      prev_we = mem_we_n;
      prev_oe = mem_oe_n;
    end
  end

  // One access; called at a negedge, returns at the negedge of the acknowledge
  task automatic do_op(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    int n;
    int exp_lat;
    exp_lat = (wr ? (WP + HOLD) : ACC) + 1 + ((have_prev && prev_wr != wr) ? TURN : 0);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    chk(req_ready, "R2 ready while idle", {31'd0, req_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = 16'h0BAD;
    n = 1;
    chk(!req_ready, "R2 ready low after accept", {31'd0, req_ready}, 32'd0);
    chk(!rsp_valid, "R11 ack is a single pulse", {31'd0, rsp_valid}, 32'd0);
    while (!rsp_valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(n == exp_lat, wr ? "R11 write latency (R8 turn)" : "R11 read latency (R8 turn)", n, exp_lat);
    chk(req_ready, "R2 ready back in ack cycle", {31'd0, req_ready}, 32'd1);
    if (wr) begin
      refm[a] = merge(ref_peek(a), d, m);
    end else begin
      chk(rsp_rdata == exp_read(ref_peek(a), m),
          (m == 2'b00) ? "R10 read with empty mask" : "R3 read data per lane",
          rsp_rdata, exp_read(ref_peek(a), m));
    end
    have_prev = 1'b1;
    prev_wr   = wr;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    chk({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n} == 5'b11111, "R1 strobes high in reset",
        {27'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 32'h1F);
    chk(!mem_dq_oe && !rsp_valid, "R1 bus released in reset", {30'd0, mem_dq_oe, rsp_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && mem_ce_n && !mem_dq_oe, "R1 idle after reset",
        {29'd0, req_ready, mem_ce_n, mem_dq_oe}, 32'd6);

    // Directed corners
    do_op(1, 16'h0000, 16'hA1B2, 2'b11);
    do_op(0, 16'h0000, 16'h0000, 2'b11);            // R3, R8 turn
    do_op(1, 16'h0000, 16'hFF77, 2'b01);            // R4 lower only
    do_op(1, 16'h0000, 16'h66EE, 2'b10);            // R4 upper only
    do_op(0, 16'h0000, 16'h0000, 2'b11);
    chk(rsp_rdata == 16'h6677, "R4 lanes merged", rsp_rdata, 32'h6677);
    do_op(1, 16'hFFFF, 16'h1357, 2'b11);
    do_op(1, 16'hFFFF, 16'h9999, 2'b00);            // R10 empty write
    do_op(0, 16'hFFFF, 16'h0000, 2'b11);
    chk(rsp_rdata == 16'h1357, "R10 empty write left memory", rsp_rdata, 32'h1357);
    do_op(0, 16'hFFFF, 16'h0000, 2'b01);            // R3 lower lane only
    do_op(0, 16'hFFFF, 16'h0000, 2'b10);            // R3 upper lane only
    do_op(0, 16'hFFFF, 16'h0000, 2'b00);            // R10 empty read

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      a = 16'($urandom_range(0, 15)) ^ (($urandom_range(0, 1) == 1) ? 16'hFFF0 : 16'h0000);
      do_op(($urandom_range(0, 2) != 0), a, 16'($urandom), 2'($urandom_range(0, 3)));
    end

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule